// File: doc/BRIEF.md
# Configurable Serial Receiver with Sticky Error Status

This block receives characters from an asynchronous serial line. One 8-bit control word sets the frame shape: the number of data bits, whether a parity bit is present and which sense it has, the number of stop bits, and the line rate. The receiver runs a 16x oversampling tick derived from the system clock. It confirms each start bit at its midpoint and then samples every later bit at its centre. Each finished character goes into a small first-word-fall-through receive queue. The head of that queue always sits on the read-data port.

Four sticky flags report line trouble: a parity mismatch, a missing stop bit, a character lost because the queue was full, and a line held low for longer than a whole frame. A flag stays set until a clear pulse arrives. A new error that lands in the same cycle as the clear still sets its flag.

The control state machine has these states: IDLE (line high, waiting), START (counting to the start-bit midpoint), DATA (sampling data bits), PARITY (sampling the parity bit), STOP1 and STOP2 (sampling stop bits), and HOLD (after a low stop bit, waiting for the line to go high). The transitions are:
- IDLE→START on a low sample.
- START→IDLE if the midpoint sample is high.
- START→DATA if the midpoint sample is low.
- DATA→PARITY or DATA→STOP1 after the last data bit, depending on whether parity is enabled.
- PARITY→STOP1.
- STOP1→STOP2 when two stop bits are selected.
- STOP1 or STOP2→IDLE when the final stop sample is high.
- STOP1 or STOP2→HOLD when the final stop sample is low.
- HOLD→IDLE once the line is high.

Top module: `uart_rx_stat`

## Requirements
- R1: The line idles high. A frame is a low start bit, then data bits least significant first, then an optional parity bit, then stop bits. Control bits 6:5 give the data length: 00 means 6 bits, 01 means 7 bits, 10 or 11 means 8 bits. Unused upper bits of the read data are 0.
- R2: Control bit 4 set means a parity bit follows the data. Control bit 3 set selects odd parity and clear selects even parity. When bit 4 is clear, no parity bit is expected and bit 3 has no effect.
- R3: Control bit 7 clear means one stop bit and set means two stop bits. In both cases every stop bit is sampled.
- R4: Control bits 2:0 set the tick divider. 000 gives 8×BASE_DIV clocks per tick, 001 gives 4×, 010 gives 2×, and 011 or any higher code gives 1×. These are the 2400, 4800, 9600 and 19200 rates when BASE_DIV matches 19200×16. One bit lasts 16 ticks.
- R5: The start bit is accepted only if the line is still low at its midpoint, 8 ticks after the falling edge is seen. A shorter low pulse is ignored and stores nothing.
- R6: The parity flag is set when the received parity bit differs from the parity computed over the received data bits. The character is still stored.
- R7: The framing flag is set when any stop bit is sampled low. The character is still stored.
- R8: When a character completes while the queue is full, the overrun flag is set, the new character is discarded and the queued contents are kept.
- R9: The break flag is set when the line stays low for more than one full frame time, counted in ticks as (start + data + parity + stop bits)×16. A frame of all-zero data does not set it.
- R10: All flags are sticky until a clear pulse. A flag set in the same cycle as the clear stays set.
- R11: After reset the queue is empty and all flags are 0. The read strobe removes the head character. A read strobe while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Asynchronous serial input |
| ctrl | input | 8 | Frame format and rate control word |
| rd | input | 1 | Read strobe: pops the queue head |
| clr | input | 1 | Clears all sticky flags |
| rd_data | output | 8 | Head of the receive queue |
| empty | output | 1 | Receive queue is empty |
| err_parity | output | 1 | Sticky parity mismatch flag |
| err_frame | output | 1 | Sticky missing-stop-bit flag |
| err_overrun | output | 1 | Sticky lost-character flag |
| err_break | output | 1 | Sticky line-break flag |

## Verification
The bench builds the block with BASE_DIV=2 and FIFO_DEPTH=4. With BASE_DIV=2, one bit at the fastest code is only 32 clocks, so the sweep can cover every combination of data length, parity enable, parity sense and stop count with several data patterns each. It also visits all eight rate codes. The four-entry queue makes an overrun reachable with five back-to-back frames, and a break is reached after a few hundred clocks of low line.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2, S_HOLD
    } rx_state_t;

    typedef struct packed {
        logic       stop2;
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic [2:0] rate;
    } line_cfg_t;

    localparam int FLAG_PAR = 0;
    localparam int FLAG_FRM = 1;
    localparam int FLAG_OVR = 2;
    localparam int FLAG_BRK = 3;

    function automatic logic [3:0] data_len(input logic [1:0] code);
        unique case (code)
            2'b00:   return 4'd6;
            2'b01:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int BASE_DIV = 163
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate,
    output logic       tick
);
    localparam int DIV_MAX = BASE_DIV * 8;
    localparam int CW      = $clog2(DIV_MAX + 1);

    logic [CW-1:0] div;
    logic [CW-1:0] cnt;

    always_comb begin
        unique case (rate)
            3'd0:    div = CW'(BASE_DIV * 8);
            3'd1:    div = CW'(BASE_DIV * 4);
            3'd2:    div = CW'(BASE_DIV * 2);
            default: div = CW'(BASE_DIV);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - CW'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxs,
    input  line_cfg_t cfg,
    output logic      push,
    output logic [7:0] push_data,
    output logic      push_perr,
    output logic      push_ferr
);
    localparam int TW = $clog2(OSR);

    rx_state_t   state, state_n;
    logic [TW-1:0] tcnt;
    logic [2:0]  bidx;
    logic [7:0]  shreg;
    logic        perr_q, ferr_q;
    logic        push_q, push_perr_q, push_ferr_q;
    logic [7:0]  push_data_q;
    logic        mid, last, last_bit, finish;
    logic [3:0]  nbits;

    assign nbits    = data_len(cfg.len);
    assign mid      = (tcnt == TW'(OSR / 2 - 1));
    assign last     = (tcnt == TW'(OSR - 1));
    assign last_bit = ({1'b0, bidx} == nbits - 4'd1);
    assign finish   = tick && last &&
                      ((state == S_STOP2) || (state == S_STOP1 && !cfg.stop2));

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (tick && !rxs) state_n = S_START;
            S_START:  if (tick && mid) state_n = rxs ? S_IDLE : S_DATA;
            S_DATA:   if (tick && last && last_bit)
                          state_n = cfg.par_en ? S_PARITY : S_STOP1;
            S_PARITY: if (tick && last) state_n = S_STOP1;
            S_STOP1:  if (tick && last)
                          state_n = cfg.stop2 ? S_STOP2 : (rxs ? S_IDLE : S_HOLD);
            S_STOP2:  if (tick && last) state_n = rxs ? S_IDLE : S_HOLD;
            S_HOLD:   if (rxs) state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // datapath: counters, shifter, error accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt        <= '0;
            bidx        <= '0;
            shreg       <= '0;
            perr_q      <= 1'b0;
            ferr_q      <= 1'b0;
            push_q      <= 1'b0;
            push_data_q <= '0;
            push_perr_q <= 1'b0;
            push_ferr_q <= 1'b0;
        end else begin
            push_q <= finish;
            if (finish) begin
                push_data_q <= shreg;
                push_perr_q <= perr_q;
                push_ferr_q <= ferr_q | !rxs;
            end
            if (tick) begin
                unique case (state)
                    S_IDLE: tcnt <= '0;
                    S_START: begin
                        tcnt <= mid ? '0 : tcnt + TW'(1);
                        if (mid) begin
                            bidx   <= '0;
                            shreg  <= '0;
                            perr_q <= 1'b0;
                            ferr_q <= 1'b0;
                        end
                    end
                    S_DATA: begin
                        tcnt <= tcnt + TW'(1);
                        if (last) begin
                            shreg[bidx] <= rxs;
                            bidx        <= bidx + 3'd1;
                        end
                    end
                    S_PARITY: begin
                        tcnt <= tcnt + TW'(1);
                        if (last) perr_q <= rxs ^ (^shreg) ^ cfg.par_odd;
                    end
                    S_STOP1, S_STOP2: begin
                        tcnt <= tcnt + TW'(1);
                        if (last) ferr_q <= ferr_q | !rxs;
                    end
                    default: tcnt <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        push      = push_q;
        push_data = push_data_q;
        push_perr = push_perr_q;
        push_ferr = push_ferr_q;
    end
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxs,
    input  line_cfg_t cfg,
    output logic      brk
);
    localparam int BW = $clog2(12 * OSR + 2);

    logic [BW-1:0] cnt;
    logic [BW-1:0] limit;
    logic [3:0]    fbits;

    assign fbits = 4'd2 + data_len(cfg.len) + {3'd0, cfg.par_en} + {3'd0, cfg.stop2};
    assign limit = BW'(fbits) * BW'(OSR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            brk <= 1'b0;
        end else begin
            brk <= 1'b0;
            if (rxs) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt <= limit) cnt <= cnt + BW'(1);
                brk <= (cnt == limit);
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            end
            if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int BASE_DIV   = 163,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    input  logic [7:0] ctrl,
    input  logic       rd,
    input  logic       clr,
    output logic [7:0] rd_data,
    output logic       empty,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       err_break
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    line_cfg_t  cfg;
    logic [1:0] rx_meta;
    logic       rx_s, tick;
    logic       push, perr, ferr, brk;
    logic [7:0] push_data;
    logic       fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    logic [3:0] st_set, flags_q;

    assign cfg  = line_cfg_t'(ctrl);
    assign rx_s = rx_meta[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_meta <= 2'b11;
        else        rx_meta <= {rx_meta[0], rx};
    end

    uart_rx_tick #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate(cfg.rate), .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rx_s), .cfg(cfg),
        .push(push), .push_data(push_data), .push_perr(perr), .push_ferr(ferr)
    );

    uart_rx_break u_break (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rx_s), .cfg(cfg), .brk(brk)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_data), .pop(rd),
        .dout(rd_data), .empty(empty), .full(fifo_full), .count(fifo_cnt)
    );

    always_comb begin
        st_set           = '0;
        st_set[FLAG_PAR] = push && perr;
        st_set[FLAG_FRM] = push && ferr;
        st_set[FLAG_OVR] = push && fifo_full;
        st_set[FLAG_BRK] = brk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flags_q <= '0;
        else if (clr) flags_q <= st_set;
        else          flags_q <= flags_q | st_set;
    end

    assign err_parity  = flags_q[FLAG_PAR];
    assign err_frame   = flags_q[FLAG_FRM];
    assign err_overrun = flags_q[FLAG_OVR];
    assign err_break   = flags_q[FLAG_BRK];
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd,
    input logic             clr,
    input logic [7:0]       rd_data,
    input logic [3:0]       flags,
    input logic [3:0]       st_set,
    input logic             push,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             rxs
);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != 4'd0) && !clr |=> ((flags & $past(flags)) == $past(flags)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr && (st_set == 4'd0) |=> (flags == 4'd0));

    a_r8_keep_contents: assert property (@(posedge clk) disable iff (!rst_n)
        push && fifo_full && !rd |=> $stable(rd_data) && fifo_full);

    a_r11_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (fifo_cnt != '0) && !push |=> (fifo_cnt == $past(fifo_cnt) - CNT_W'(1)));

    a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd && (fifo_cnt == '0) && !push |=> (fifo_cnt == '0));

    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        st_set[3] |-> !rxs);
endmodule

bind uart_rx_stat uart_rx_stat_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd), .clr(clr), .rd_data(rd_data),
    .flags(flags_q), .st_set(st_set), .push(push), .fifo_full(fifo_full),
    .fifo_cnt(fifo_cnt), .rxs(rx_s)
);

// File: tb/uart_rx_stat_bench.sv
`timescale 1ns/1ps
module uart_rx_stat_bench;
    localparam int BD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] ctrl = 8'h63;
    logic       rd = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] rd_data;
    logic       empty, err_parity, err_frame, err_overrun, err_break;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_stat #(.BASE_DIV(BD), .FIFO_DEPTH(4)) u_uart_rx_stat (
        .clk(clk), .rst_n(rst_n), .rx(rx), .ctrl(ctrl), .rd(rd), .clr(clr),
        .rd_data(rd_data), .empty(empty), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .err_break(err_break)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_clks(input logic [7:0] c);
        int m;
        m = (c[2:0] == 3'd0) ? 8 : (c[2:0] == 3'd1) ? 4 : (c[2:0] == 3'd2) ? 2 : 1;
        return BD * m * 16;
    endfunction

    function automatic int nbits_of(input logic [7:0] c);
        return (c[6:5] == 2'b00) ? 6 : (c[6:5] == 2'b01) ? 7 : 8;
    endfunction

    task automatic drive_bit(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int bc, nb;
        logic p;
        bc = bit_clks(ctrl);
        nb = nbits_of(ctrl);
        drive_bit(1'b0, bc);
        for (int i = 0; i < nb; i++) drive_bit(d[i], bc);
        if (ctrl[4]) begin
            p = 1'b0;
            for (int i = 0; i < nb; i++) p = p ^ d[i];
            drive_bit(p ^ ctrl[3] ^ bad_par, bc);
        end
        drive_bit(!bad_stop, bc);
        if (ctrl[7]) drive_bit(1'b1, bc);
        drive_bit(1'b1, bc / 2);
    endtask

    task automatic pop();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, mask;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset empty", 32'(empty), 32'd1);
        chk("R11 reset flags", {28'd0, err_break, err_overrun, err_frame, err_parity}, 32'd0);
        pop();
        chk("R11 read while empty", 32'(empty), 32'd1);

        // R1 R2 R3 format sweep at fastest rate
        for (int len = 0; len < 4; len++)
            for (int pe = 0; pe < 2; pe++)
                for (int od = 0; od < 2; od++)
                    for (int st = 0; st < 2; st++)
                        for (int k = 0; k < 3; k++) begin
                            ctrl = {st[0], len[1:0], pe[0], od[0], 3'd3};
                            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'hA5 ^ (len * 37 + pe * 11 + od * 5 + st * 3));
                            mask = 8'((1 << nbits_of(ctrl)) - 1);
                            send(d, 1'b0, 1'b0);
                            chk("R1 char present", 32'(empty), 32'd0);
                            chk("R1 data", 32'(rd_data), 32'(d & mask));
                            chk("R2 no parity error", 32'(err_parity), 32'd0);
                            chk("R3 no framing error", 32'(err_frame), 32'd0);
                            chk("R9 no break on frame", 32'(err_break), 32'd0);
                            pop();
                            chk("R11 popped", 32'(empty), 32'd1);
                        end

        // R4 every rate code
        for (int r = 0; r < 8; r++) begin
            ctrl = {3'b011, 2'b00, r[2:0]};
            repeat (40) @(negedge clk);
            send(8'h3C ^ 8'(r), 1'b0, 1'b0);
            chk("R4 rate data", 32'(rd_data), 32'(8'h3C ^ 8'(r)));
            pop();
        end
        ctrl = 8'h63;
        repeat (40) @(negedge clk);

        // R6 parity errors, even then odd
        ctrl = 8'h73;
        send(8'h5A, 1'b1, 1'b0);
        chk("R6 parity flag even", 32'(err_parity), 32'd1);
        chk("R6 char stored", 32'(rd_data), 32'h5A);
        pop();
        send(8'h11, 1'b0, 1'b0);
        chk("R10 parity sticky", 32'(err_parity), 32'd1);
        pop();
        clear();
        chk("R10 cleared", 32'(err_parity), 32'd0);
        ctrl = 8'h7B;
        send(8'h81, 1'b1, 1'b0);
        chk("R6 parity flag odd", 32'(err_parity), 32'd1);
        pop();
        clear();

        // R7 framing, single and double stop
        ctrl = 8'h63;
        send(8'hC3, 1'b0, 1'b1);
        chk("R7 framing flag", 32'(err_frame), 32'd1);
        chk("R7 char stored", 32'(rd_data), 32'hC3);
        pop();
        clear();
        ctrl = 8'hE3;
        send(8'h3E, 1'b0, 1'b1);
        chk("R3 two-stop framing", 32'(err_frame), 32'd1);
        pop();
        clear();
        ctrl = 8'h63;

        // R5 short low pulse ignored
        drive_bit(1'b0, 8);
        drive_bit(1'b1, 3 * bit_clks(ctrl));
        chk("R5 glitch ignored", 32'(empty), 32'd1);
        chk("R5 no flags", {28'd0, err_break, err_overrun, err_frame, err_parity}, 32'd0);

        // R8 overrun
        for (int i = 0; i < 5; i++) send(8'(8'h10 + i), 1'b0, 1'b0);
        chk("R8 overrun flag", 32'(err_overrun), 32'd1);
        for (int i = 0; i < 4; i++) begin
            chk("R8 kept contents", 32'(rd_data), 32'(8'h10 + i));
            pop();
        end
        chk("R8 new char dropped", 32'(empty), 32'd1);
        clear();

        // R9 break
        drive_bit(1'b0, 20 * bit_clks(ctrl));
        drive_bit(1'b1, 2 * bit_clks(ctrl));
        chk("R9 break flag", 32'(err_break), 32'd1);
        chk("R9 framing with break", 32'(err_frame), 32'd1);
        chk("R9 zero char", 32'(rd_data), 32'h00);
        pop();
        clear();
        chk("R10 all cleared", {28'd0, err_break, err_overrun, err_frame, err_parity}, 32'd0);
        chk("R11 empty at end", 32'(empty), 32'd1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule